// File: doc/BRIEF.md
# PHY Management Register Bridge

This block gives a host one 32-bit control word through which it runs management cycles against a bank of PHY registers. A host write to the control address stores the whole word. If the opcode field of that word asks for a write, the 16-bit data field goes straight into a register file. The file is indexed by the PHY address field and the register number field. A later host read of the control address returns the stored word with the ready flag set. When the stored opcode asks for a read, the low half of the returned word is replaced by the value of the addressed PHY register.

Every cycle completes at once, so the host never has to poll for ready. No serial management pins are driven. Identity and capability registers answer with hard-wired constants, and the basic control register reads back through a fixed mask. Every other register returns whatever was last written to it.

The host port is a plain synchronous register port. It accepts one access per cycle and never stalls, so it has no back-pressure. Read data comes back registered, one cycle after the read strobe. The number of PHYs held is a parameter and must be a power of two, from 2 to 32.

Top module: `mgmt_reg_bridge`

## Requirements
- R1: A write with reg_addr equal to CTRL_ADDR (default 0x10) stores all 32 bits of reg_wdata into the control word. A following read of CTRL_ADDR returns bits 31:29 and 27:16 of that word unchanged, and the control word is 0 after reset.
- R2: When a written control word has opcode bits 27:26 equal to 1, its bits 15:0 are stored in the register selected by PHY address bits 25:21 and register number bits 20:16. Opcodes 0, 2 and 3 store nothing.
- R3: A read of CTRL_ADDR while the stored opcode is 2 returns the addressed PHY register in bits 15:0. With any other stored opcode, bits 15:0 are the data field of the stored word.
- R4: Bit 28 of every word returned by a read of CTRL_ADDR is 1.
- R5: Register number 0 reads as its stored value with bits 15 and 9 cleared and bit 13 set.
- R6: Register numbers 1, 2, 3, 5, 6 and 17 read as 0x782C, 0x0013, 0x61D4, 0x41E1, 0x0001 and 0x4700 for any PHY address. Writes to them have no visible effect.
- R7: All other register numbers read as the last value written, or 0 if nothing has been written since reset.
- R8: A PHY address of NUM_PHY (default 4) or above never stores data. Its non-fixed registers read as 0, and it does not alias a lower PHY.
- R9: reg_rdata is updated on the clock edge at which reg_rd is sampled and is 0 in every other cycle. A read of any address other than CTRL_ADDR returns 0, and a write to any other address changes nothing.
- R10: When reg_wr and reg_rd are high in the same cycle, the write is performed and no read is served, so reg_rdata is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (8) | Host register address |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, valid the cycle after reg_rd |

## Verification
On every cycle, properties check four things: the ready flag on each served read, the zero data in cycles without a served read, the upper bits passed through from the control word, and that each opcode-1 write lands in the register file. For reads of register 0 and register 1 with the read opcode, they also check the control-register mask and the first identity constant. The other constants, the opcodes that store nothing, out-of-range PHY addresses and their non-aliasing, and the behaviour of foreign addresses can only be shown by the bench's write-then-read scenarios. The same holds for the simultaneous write-and-read case, because each of these depends on what was written earlier.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int DATA_W = 16;
  localparam int REGN_W = 5;
  localparam int PHYA_W = 5;

  localparam int RDY_BIT  = 28;
  localparam int OP_LSB   = 26;
  localparam int PHY_LSB  = 21;
  localparam int REGN_LSB = 16;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_RSVD  = 2'd3
  } mgmt_op_e;

  typedef struct packed {
    mgmt_op_e              op;
    logic [PHYA_W-1:0]     phy;
    logic [REGN_W-1:0]     regn;
    logic [DATA_W-1:0]     data;
  } mgmt_fields_t;

  function automatic mgmt_fields_t split_word(input logic [31:0] w);
    mgmt_fields_t f;
    f.op   = mgmt_op_e'(w[OP_LSB +: 2]);
    f.phy  = w[PHY_LSB +: PHYA_W];
    f.regn = w[REGN_LSB +: REGN_W];
    f.data = w[DATA_W-1:0];
    return f;
  endfunction
endpackage

// File: rtl/mgmt_phy_regfile.sv
module mgmt_phy_regfile #(
  parameter int NUM_PHY = 4,
  parameter int REGS    = 32,
  localparam int PHY_IDX_W = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1,
  localparam int REG_IDX_W = $clog2(REGS),
  localparam int IDX_W     = PHY_IDX_W + REG_IDX_W,
  localparam int DEPTH     = NUM_PHY * REGS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [15:0]      wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [15:0]      rd_data
);
  logic [15:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];

  // R2: an accepted write is held in the addressed entry
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/mgmt_value_overlay.sv
module mgmt_value_overlay (
  input  logic [4:0]  regn,
  input  logic        present,
  input  logic [15:0] stored,
  output logic [15:0] value
);
  logic [15:0] raw;

  assign raw = present ? stored : 16'h0000;

  always_comb begin
    case (regn)
      5'd0:    value = (raw & 16'h7DFF) | 16'h2000;
      5'd1:    value = 16'h782C;
      5'd2:    value = 16'h0013;
      5'd3:    value = 16'h61D4;
      5'd5:    value = 16'h41E1;
      5'd6:    value = 16'h0001;
      5'd17:   value = 16'h4700;
      default: value = raw;
    endcase
  end
endmodule

// File: rtl/mgmt_reg_bridge.sv
module mgmt_reg_bridge
  import mgmt_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h10,
  parameter int              NUM_PHY   = 4,
  localparam int REGS      = 1 << REGN_W,
  localparam int PHY_IDX_W = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1,
  localparam int IDX_W     = PHY_IDX_W + REGN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  logic         addr_hit, wr_hit, rd_hit;
  logic [31:0]  ctrl_q;
  mgmt_fields_t wf, cf;
  logic         w_in_range, c_in_range;
  logic [IDX_W-1:0] w_idx, c_idx;
  logic [15:0]  stored_val, shown_val;

  assign addr_hit = (reg_addr == CTRL_ADDR);
  assign wr_hit   = reg_wr && addr_hit;
  assign rd_hit   = reg_rd && !reg_wr && addr_hit;

  assign wf = split_word(reg_wdata);
  assign cf = split_word(ctrl_q);

  assign w_in_range = ({1'b0, wf.phy} < 6'(NUM_PHY));
  assign c_in_range = ({1'b0, cf.phy} < 6'(NUM_PHY));
  assign w_idx = {wf.phy[PHY_IDX_W-1:0], wf.regn};
  assign c_idx = {cf.phy[PHY_IDX_W-1:0], cf.regn};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_hit) ctrl_q <= reg_wdata;
  end

  mgmt_phy_regfile #(.NUM_PHY(NUM_PHY), .REGS(REGS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_hit && (wf.op == OP_WRITE) && w_in_range),
    .wr_idx  (w_idx),
    .wr_data (wf.data),
    .rd_idx  (c_idx),
    .rd_data (stored_val)
  );

  mgmt_value_overlay u_overlay (
    .regn    (cf.regn),
    .present (c_in_range),
    .stored  (stored_val),
    .value   (shown_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd && !reg_wr) begin
      if (addr_hit)
        reg_rdata <= {ctrl_q[31:RDY_BIT+1], 1'b1, ctrl_q[RDY_BIT-1:16],
                      (cf.op == OP_READ) ? shown_val : ctrl_q[15:0]};
      else
        reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
    end
  end

  // R4: every served read carries the ready flag
  a_r4_ready_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> reg_rdata[RDY_BIT]);

  // R9: no served read, no data
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> reg_rdata == 32'h0);

  // R1: upper fields pass through from the stored word
  a_r1_upper_pass: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> (reg_rdata[31:29] == $past(ctrl_q[31:29])) &&
               (reg_rdata[27:16] == $past(ctrl_q[27:16])));

  // R5: control register mask on read
  a_r5_ctrl_mask: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit && (ctrl_q[27:26] == 2'd2) && (ctrl_q[20:16] == 5'd0) |=>
      !reg_rdata[15] && !reg_rdata[9] && reg_rdata[13]);

  // R6: first identity register is constant
  a_r6_ident_const: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit && (ctrl_q[27:26] == 2'd2) && (ctrl_q[20:16] == 5'd1) |=>
      reg_rdata[15:0] == 16'h782C);
endmodule

// File: tb/tb_mgmt_reg_bridge.sv
module tb_mgmt_reg_bridge;
  localparam logic [7:0] CTRL = 8'h10;
  localparam logic [7:0] OTHER = 8'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int n_checks = 0;
  int n_fails = 0;
  logic [31:0] got;

  always #2.5 clk = ~clk;

  mgmt_reg_bridge dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // {requirement number, control word written, expected read}
  localparam int NV = 20;
  localparam logic [67:0] VEC [NV] = '{
    {4'd2,  32'h0404BEEF, 32'h1404BEEF},  // R2 write phy0 reg4
    {4'd3,  32'h08040000, 32'h1804BEEF},  // R3 read it back
    {4'd2,  32'h0420FFFF, 32'h1420FFFF},  // R2 write phy1 reg0
    {4'd5,  32'h08200000, 32'h18207DFF},  // R5 masked
    {4'd5,  32'h08400000, 32'h18402000},  // R5 zero stored
    {4'd1,  32'h04611234, 32'h14611234},  // R1 write to fixed reg
    {4'd6,  32'h08610000, 32'h1861782C},  // R6 reg1
    {4'd6,  32'h08020000, 32'h18020013},  // R6 reg2
    {4'd6,  32'h08230000, 32'h182361D4},  // R6 reg3
    {4'd6,  32'h08050000, 32'h180541E1},  // R6 reg5
    {4'd6,  32'h08060000, 32'h18060001},  // R6 reg6
    {4'd6,  32'h08110000, 32'h18114700},  // R6 reg17
    {4'd1,  32'h245FA5A5, 32'h345FA5A5},  // R1 bit29 kept
    {4'd7,  32'h085F1111, 32'h185FA5A5},  // R7 phy2 reg31
    {4'd2,  32'h00075555, 32'h10075555},  // R2 opcode 0
    {4'd2,  32'h08070000, 32'h18070000},  // R2 nothing stored
    {4'd2,  32'h0C076666, 32'h1C076666},  // R2 opcode 3
    {4'd2,  32'h08070000, 32'h18070000},  // R2 still nothing
    {4'd8,  32'h04847777, 32'h14847777},  // R8 out-of-range write
    {4'd8,  32'h08840000, 32'h18840000}   // R8 reads zero
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL R%0d: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  initial begin
    #200000;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(9, reg_rdata, 32'h0);            // R9 reset output
    rst_n = 1'b1;
    rd(CTRL, got);
    check(1, got, 32'h10000000);           // R1 reset word, R4 ready
    wr(CTRL, 32'h08080000);
    rd(CTRL, got);
    check(7, got, 32'h18080000);           // R7 reset zero

    for (int i = 0; i < NV; i++) begin
      wr(CTRL, VEC[i][63:32]);
      rd(CTRL, got);
      check(int'(VEC[i][67:64]), got, VEC[i][31:0]);
    end

    wr(CTRL, 32'h08040000);
    rd(CTRL, got);
    check(8, got, 32'h1804BEEF);           // R8 no alias into phy0
    wr(CTRL, 32'h08810000);
    rd(CTRL, got);
    check(8, got, 32'h1881782C);           // R8 fixed still applies

    wr(CTRL, 32'h04095A5A);
    rd(OTHER, got);
    check(9, got, 32'h0);                  // R9 foreign read
    @(negedge clk);
    check(9, reg_rdata, 32'h0);            // R9 idle after read
    wr(OTHER, 32'h04093C3C);
    rd(CTRL, got);
    check(9, got, 32'h14095A5A);           // R9 foreign write ignored
    wr(CTRL, 32'h08090000);
    rd(CTRL, got);
    check(9, got, 32'h18095A5A);           // R9 register unchanged

    @(negedge clk);
    reg_addr = CTRL; reg_wdata = 32'h040A1357; reg_wr = 1'b1; reg_rd = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_rd = 1'b0;
    check(10, reg_rdata, 32'h0);           // R10 read not served
    wr(CTRL, 32'h080A0000);
    rd(CTRL, got);
    check(10, got, 32'h180A1357);          // R10 write performed
    check(4, got & 32'h10000000, 32'h10000000); // R4 ready flag

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule